// File: doc/BRIEF.md
# Atomic Memory Synchronization Unit

This unit sits in front of a small word-addressed memory and carries out synchronization operations for several requesters. Each requester presents an operation code, a word address and a write value, and holds its request until the unit grants it. Only one request is granted per clock, so every operation runs indivisibly. Available operations are plain load and store, atomic swap, test-and-set, fetch-and-increment, and a load-linked / store-conditional pair.

A lock word holds 0 when free and 1 when taken. A requester can take the lock in three ways: a swap that writes 1 and returns 0, a test-and-set that returns 0, or a load-linked followed by a successful store-conditional. It gives the lock back with a plain store of 0. Every requester has one reservation, which is a valid bit and an address. Load-linked sets it. Any write by another requester to that word cancels it.

Top module: `sync_mem_unit`

## Requirements
- R1: After reset no response is valid, every memory word reads 0 and no requester holds a reservation.
- R2: Opcode 0 (load) returns the word and leaves it unchanged. Opcode 1 (store) writes the request value and returns the word's prior value.
- R3: Opcode 2 (swap) writes the request value and returns the prior word in the same operation.
- R4: Opcode 3 (test-and-set) returns the prior word. It writes 1 only when that prior word was 0, and otherwise leaves the word unchanged.
- R5: Opcode 4 (fetch-and-increment) returns the prior word and stores that word plus one, wrapping from all-ones to 0.
- R6: Opcode 5 (load-linked) returns the word and sets the requester's reservation on that address. Opcode 6 (store-conditional) with a valid reservation on the same address writes the request value and returns 1.
- R7: A store-conditional without a matching reservation returns 0 and leaves memory unchanged. A reservation is lost whenever another requester writes that word by store, swap, successful test-and-set, increment or successful store-conditional.
- R8: Any store-conditional clears its own requester's reservation, whether it succeeds or fails. A new load-linked replaces the earlier reservation.
- R9: At most one valid request is granted per cycle. When any request is valid, one is granted. Priority is round-robin, starting after the last granted requester, with requester 0 first after reset.
- R10: The response appears exactly one cycle after the grant, carrying the granted requester's index.
- R11: A requester's own write to its reserved word does not cancel its reservation. A test-and-set that finds a nonzero word writes nothing and cancels no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_REQ | Request pending, one bit per requester, held until granted |
| req_op | input | 3*NUM_REQ | Opcode per requester, requester i in bits [3i+2:3i] |
| req_addr | input | log2(DEPTH)*NUM_REQ | Word address per requester |
| req_wdata | input | DATA_W*NUM_REQ | Write value per requester |
| req_gnt | output | NUM_REQ | Combinational one-hot grant for this cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | log2(NUM_REQ) | Index of the requester the response belongs to |
| rsp_data | output | DATA_W | Prior word, or 1/0 success flag for store-conditional |

## Verification
Directed lock sequences use swap, test-and-set and load-linked / store-conditional. Each is run on a free word and on a held word, which tells a correct acquire apart from a false one. A wrap case checks that the increment overflows to 0 and does not saturate. Reservation cases interleave a second requester's write, a failing test-and-set, the owner's own store and a repeated load-linked, which separates cancellation by others from cancellation by self. All four requesters contend at once, from two different priority positions, to expose ordering and lost-update errors. A long run of random operations on four addresses with small values then mixes every opcode against a bench model.

// File: rtl/syncmem_pkg.sv
// Shared opcode encoding for the atomic memory synchronization unit.
package syncmem_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_SWAP  = 3'd2,
        OP_TAS   = 3'd3,
        OP_FINC  = 3'd4,
        OP_LL    = 3'd5,
        OP_SC    = 3'd6,
        OP_RSVD  = 3'd7
    } sm_op_e;
    localparam int SM_OPW = 3;
endpackage

// File: rtl/rr_arbiter.sv
// Round-robin arbiter: grants one of N requests per cycle, combinationally.
// Assumes requests are held until granted; priority restarts after the
// last winner, requester 0 first out of reset.
module rr_arbiter #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr;
    logic          found;
    int            idx;

    // Pick the first pending request at or after the priority pointer.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        idx     = 0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                found        = 1'b1;
                gnt[idx]     = 1'b1;
                gnt_idx      = IW'(idx);
            end
        end
    end

    // Move priority to the requester after the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (found)
            ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
    end

    // R9
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R9
    gnt_only_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    // R9
    gnt_work_conserving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt));
endmodule

// File: rtl/word_mem.sv
// Register-based word memory: combinational read, one synchronous write.
// Assumes at most one write per cycle; all words clear on reset.
module word_mem #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] words [DEPTH];

    genvar i;
    for (i = 0; i < DEPTH; i++) begin : g_word
        logic [DATA_W-1:0] q;
        // Hold one word; load it when addressed by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_addr == AW'(i))
                q <= wr_data;
        end
        assign words[i] = q;
    end

    // Read port.
    assign rd_data = words[rd_addr];

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> words[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/resv_table.sv
// Per-requester load-linked reservations (valid bit plus address).
// Assumes one operation per cycle; reports whether the current
// requester still holds a reservation on the current address.
module resv_table
    import syncmem_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [$clog2(N)-1:0] op_id,
    input  sm_op_e               op_code,
    input  logic [AW-1:0]        op_addr,
    input  logic                 wr_en,
    output logic                 own_hit
);
    localparam int IW = $clog2(N);

    logic          rv [N];
    logic [AW-1:0] ra [N];

    genvar i;
    for (i = 0; i < N; i++) begin : g_slot
        logic          v;
        logic [AW-1:0] a;
        logic          mine;
        assign mine = op_valid && (op_id == IW'(i));
        // Set on own load-linked, drop on own store-conditional or a foreign write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v <= 1'b0;
                a <= '0;
            end else if (mine && op_code == OP_LL) begin
                v <= 1'b1;
                a <= op_addr;
            end else if (mine && op_code == OP_SC) begin
                v <= 1'b0;
            end else if (op_valid && wr_en && !mine && a == op_addr) begin
                v <= 1'b0;
            end
        end
        assign rv[i] = v;
        assign ra[i] = a;

        // R7
        foreign_write_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && wr_en && op_id != IW'(i)) |=> !(v && a == $past(op_addr)));
        // R8
        sc_clears_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op_code == OP_SC && op_id == IW'(i)) |=> !v);
    end

    // Reservation lookup for the granted requester.
    assign own_hit = rv[op_id] && (ra[op_id] == op_addr);
endmodule

// File: rtl/sync_mem_unit.sv
// Atomic memory synchronization unit: arbitrates requesters, executes one
// read-modify-write per cycle on a small word memory, and returns the
// prior word (or a store-conditional flag) one cycle after the grant.
// Assumes requesters hold their request until they see their grant bit.
module sync_mem_unit
    import syncmem_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int DEPTH   = 16,
    parameter int DATA_W  = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_REQ-1:0]                req_valid,
    input  logic [NUM_REQ*SM_OPW-1:0]         req_op,
    input  logic [NUM_REQ*$clog2(DEPTH)-1:0]  req_addr,
    input  logic [NUM_REQ*DATA_W-1:0]         req_wdata,
    output logic [NUM_REQ-1:0]                req_gnt,
    output logic                              rsp_valid,
    output logic [$clog2(NUM_REQ)-1:0]        rsp_id,
    output logic [DATA_W-1:0]                 rsp_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int IW = $clog2(NUM_REQ);

    logic [NUM_REQ-1:0] gnt;
    logic [IW-1:0]      gidx;
    logic               any_gnt;
    sm_op_e             op_code;
    logic [AW-1:0]      op_addr;
    logic [DATA_W-1:0]  op_wdata;
    logic [DATA_W-1:0]  old_word;
    logic [DATA_W-1:0]  new_word;
    logic [DATA_W-1:0]  result;
    logic               do_write;
    logic               wr_en;
    logic               own_hit;

    rr_arbiter #(.N(NUM_REQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (gidx)
    );

    assign req_gnt = gnt;
    assign any_gnt = |gnt;

    // Select the granted requester's fields.
    assign op_code  = sm_op_e'(req_op[gidx*SM_OPW +: SM_OPW]);
    assign op_addr  = req_addr[gidx*AW +: AW];
    assign op_wdata = req_wdata[gidx*DATA_W +: DATA_W];

    word_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (op_addr),
        .rd_data (old_word),
        .wr_en   (wr_en),
        .wr_addr (op_addr),
        .wr_data (new_word)
    );

    resv_table #(.N(NUM_REQ), .AW(AW)) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (any_gnt),
        .op_id    (gidx),
        .op_code  (op_code),
        .op_addr  (op_addr),
        .wr_en    (wr_en),
        .own_hit  (own_hit)
    );

    // Work out the write-back value and the response for the granted opcode.
    always_comb begin
        do_write = 1'b0;
        new_word = old_word;
        result   = old_word;
        unique case (op_code)
            OP_STORE, OP_SWAP: begin
                do_write = 1'b1;
                new_word = op_wdata;
            end
            OP_TAS: begin
                do_write = (old_word == '0);
                new_word = DATA_W'(1);
            end
            OP_FINC: begin
                do_write = 1'b1;
                new_word = old_word + 1'b1;
            end
            OP_SC: begin
                do_write = own_hit;
                new_word = op_wdata;
                result   = own_hit ? DATA_W'(1) : '0;
            end
            default: begin
                do_write = 1'b0;
            end
        endcase
    end

    assign wr_en = any_gnt && do_write;

    // Register the response one cycle after the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= any_gnt;
            rsp_id    <= gidx;
            rsp_data  <= result;
        end
    end

    // R10
    rsp_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_gnt |=> (rsp_valid && rsp_id == $past(gidx)));
    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_gnt |=> !rsp_valid);
    // R6
    sc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_gnt && op_code == OP_SC) |=> (rsp_data == '0 || rsp_data == DATA_W'(1)));
    // R4
    tas_held_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_gnt && op_code == OP_TAS && old_word != '0) |-> !wr_en);
endmodule

// File: tb/tb_sync_mem_unit.sv
`timescale 1ns/1ps
module tb_sync_mem_unit;
    localparam int N  = 4;
    localparam int D  = 16;
    localparam int W  = 32;
    localparam int AW = 4;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    req_valid;
    logic [N*3-1:0]  req_op;
    logic [N*AW-1:0] req_addr;
    logic [N*W-1:0]  req_wdata;
    logic [N-1:0]    req_gnt;
    logic            rsp_valid;
    logic [IW-1:0]   rsp_id;
    logic [W-1:0]    rsp_data;

    always #2.5 clk = ~clk;

    sync_mem_unit #(.NUM_REQ(N), .DEPTH(D), .DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_gnt(req_gnt),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [W-1:0]  m_mem [D];
    bit            m_rv  [N];
    logic [AW-1:0] m_ra  [N];
    int            m_ptr;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference behaviour taken from the requirements.
    task automatic mdl(input int id, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [W-1:0] wd, output logic [W-1:0] r);
        logic [W-1:0] old;
        logic [W-1:0] nv;
        bit wr;
        old = m_mem[a]; nv = old; r = old; wr = 1'b0;
        case (op)
            3'd1, 3'd2: begin wr = 1'b1; nv = wd; end
            3'd3: if (old == 0) begin wr = 1'b1; nv = 1; end
            3'd4: begin wr = 1'b1; nv = old + 1; end
            3'd5: begin m_rv[id] = 1'b1; m_ra[id] = a; end
            3'd6: begin
                if (m_rv[id] && m_ra[id] == a) begin wr = 1'b1; nv = wd; r = 1; end
                else r = 0;
                m_rv[id] = 1'b0;
            end
            default: ;
        endcase
        if (wr) begin
            m_mem[a] = nv;
            for (int k = 0; k < N; k++)
                if (k != id && m_ra[k] == a) m_rv[k] = 1'b0;
        end
        m_ptr = (id + 1) % N;
    endtask

    task automatic set_fields(input int id, input logic [2:0] op, input logic [AW-1:0] a, input logic [W-1:0] wd);
        req_op[id*3 +: 3]    = op;
        req_addr[id*AW +: AW] = a;
        req_wdata[id*W +: W] = wd;
    endtask

    // Issue one request alone and check grant and response.
    task automatic do_op(input int id, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [W-1:0] wd, input string tag);
        logic [W-1:0] e;
        @(negedge clk);
        set_fields(id, op, a, wd);
        req_valid = '0;
        req_valid[id] = 1'b1;
        #0.5;
        chk(req_gnt == N'(1 << id), "R9 single grant", W'(req_gnt), W'(1 << id));
        @(negedge clk);
        req_valid = '0;
        mdl(id, op, a, wd, e);
        chk(rsp_valid && rsp_id == IW'(id), "R10 rsp id", W'({rsp_valid, rsp_id}), W'({1'b1, IW'(id)}));
        chk(rsp_data == e, tag, rsp_data, e);
    endtask

    // All requesters contend with fetch-and-increment on one word.
    task automatic contend(input logic [AW-1:0] a);
        bit [N-1:0] pend;
        int exp_id;
        logic [W-1:0] e;
        @(negedge clk);
        for (int i = 0; i < N; i++) set_fields(i, 3'd4, a, '0);
        req_valid = '1;
        pend = '1;
        for (int s = 0; s < N; s++) begin
            #0.5;
            exp_id = 0;
            for (int k = N - 1; k >= 0; k--)
                if (pend[(m_ptr + k) % N]) exp_id = (m_ptr + k) % N;
            chk(req_gnt == N'(1 << exp_id), "R9 round-robin", W'(req_gnt), W'(1 << exp_id));
            @(negedge clk);
            mdl(exp_id, 3'd4, a, '0, e);
            chk(rsp_valid && rsp_id == IW'(exp_id), "R10 contended id", W'(rsp_id), W'(exp_id));
            chk(rsp_data == e, "R5 contended increment", rsp_data, e);
            req_valid[exp_id] = 1'b0;
            pend[exp_id] = 1'b0;
        end
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < D; i++) m_mem[i] = '0;
        for (int i = 0; i < N; i++) begin m_rv[i] = 1'b0; m_ra[i] = '0; end
        m_ptr = 0;
        rst_n = 1'b0; req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", W'(rsp_valid), 0);
        do_op(0, 3'd0, 4'd15, 0, "R1 reset word zero");
        do_op(1, 3'd6, 4'd0, 32'h55, "R1 no reservation at reset");
        do_op(1, 3'd0, 4'd0, 0, "R1 failed SC left word");

        do_op(2, 3'd1, 4'd3, 32'h1234, "R2 store returns old");
        do_op(3, 3'd0, 4'd3, 0, "R2 load after store");
        do_op(3, 3'd0, 4'd3, 0, "R2 load leaves word");

        do_op(0, 3'd2, 4'd1, 1, "R3 swap acquires free lock");
        do_op(1, 3'd2, 4'd1, 1, "R3 swap on held lock");
        do_op(0, 3'd1, 4'd1, 0, "R2 release by store");
        do_op(2, 3'd2, 4'd1, 32'hABCD, "R3 swap after release");
        do_op(2, 3'd0, 4'd1, 0, "R3 swapped value");

        do_op(1, 3'd3, 4'd2, 0, "R4 tas free");
        do_op(2, 3'd3, 4'd2, 0, "R4 tas held");
        do_op(2, 3'd0, 4'd2, 0, "R4 word stays one");
        do_op(3, 3'd1, 4'd2, 7, "R4 set seven");
        do_op(3, 3'd3, 4'd2, 0, "R4 tas nonzero");
        do_op(3, 3'd0, 4'd2, 0, "R4 nonzero untouched");

        do_op(0, 3'd1, 4'd4, 32'hFFFF_FFFF, "R5 preset all ones");
        do_op(0, 3'd4, 4'd4, 0, "R5 increment returns old");
        do_op(1, 3'd0, 4'd4, 0, "R5 wrap to zero");

        do_op(1, 3'd5, 4'd5, 0, "R6 load-linked");
        do_op(1, 3'd6, 4'd5, 32'hAA, "R6 sc success");
        do_op(2, 3'd0, 4'd5, 0, "R6 sc wrote");

        do_op(1, 3'd5, 4'd6, 0, "R7 ll");
        do_op(2, 3'd1, 4'd6, 9, "R7 foreign store");
        do_op(1, 3'd6, 4'd6, 32'hBB, "R7 sc fails after foreign write");
        do_op(1, 3'd0, 4'd6, 0, "R7 memory unchanged");

        do_op(3, 3'd5, 4'd7, 0, "R8 ll");
        do_op(3, 3'd6, 4'd7, 5, "R8 first sc");
        do_op(3, 3'd6, 4'd7, 6, "R8 second sc fails");
        do_op(3, 3'd5, 4'd7, 0, "R8 ll first address");
        do_op(3, 3'd5, 4'd8, 0, "R8 ll replaces");
        do_op(3, 3'd6, 4'd7, 4, "R8 sc on old address fails");

        do_op(0, 3'd5, 4'd9, 0, "R11 ll");
        do_op(0, 3'd1, 4'd9, 3, "R11 own store");
        do_op(1, 3'd3, 4'd9, 0, "R11 failing tas by other");
        do_op(0, 3'd6, 4'd9, 8, "R11 sc still succeeds");

        contend(4'd10);
        do_op(2, 3'd0, 4'd11, 0, "R9 move pointer");
        contend(4'd10);

        for (int t = 0; t < 400; t++) begin
            do_op(int'($urandom % N), 3'($urandom % 7), AW'($urandom % 4),
                  W'($urandom % 3), "R2 random mix");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule